// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block puts one character per frame onto a single serial output line. The character width, the parity mode and the number of stop bits are all chosen at run time, which gives thirty legal frame shapes. A word of up to nine bits is handed over through a valid/ready handshake. It is then shifted out at one bit per baud tick, where the tick is a single-cycle enable strobe supplied from outside.

Each frame is a low start bit, then the data bits with the least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The format inputs and the data word are captured when a frame is accepted, so changing the inputs while a frame is in flight has no effect on it. A new frame can follow the last stop bit with no idle bit between them. When no word is offered, the line rests high.

Top module: `serframe_tx`

## Requirements
- R1: When `in_valid` and `in_ready` are both high at a clock edge, the line is driven low (start bit) from the next cycle until the next baud tick.
- R2: Data bits follow the start bit, least significant bit first. The number of data bits is set by `cfg_size`: 0→5, 1→6, 2→7, 3→8, 4→9, and codes 5 to 7 also give 9.
- R3: `cfg_parity` selects the parity mode: 0 = none, 1 = even, 2 = odd, 3 = none. When parity is enabled, one parity bit follows the last data bit. Only the configured data bits are counted. With even parity, the ones in data plus parity add up to an even number; with odd parity, to an odd number.
- R4: One stop bit follows, or two when `cfg_two_stop` is 1. Every stop bit is high.
- R5: The line is high while idle. A synchronous active-high `rst` returns the line high and the block to idle on the next edge, even in the middle of a frame.
- R6: `in_ready` is high only in a cycle where `baud_tick` is high and the block is either idle or sending its final stop bit.
- R7: A word accepted during the final stop bit starts its start bit right after that stop bit, with no idle bit between the frames.
- R8: The format inputs and `in_data` are sampled when the word is accepted. Changing them during a frame does not alter that frame.
- R9: Each bit stays on the line for exactly one baud period. The line changes only on the edge that ends a `baud_tick` cycle.
- R10: All 30 combinations of data size, parity mode and stop-bit count produce correctly formed frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| cfg_size | input | 3 | Data-size code (0..4 → 5..9 bits) |
| cfg_parity | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| in_data | input | 9 | Character to send, bit 0 first |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| tx_line | output | 1 | Serial output, idle high |

## Verification
The bench builds the block with its default parameters: a 9-bit data word and a 4-bit bit counter. It drives a baud tick on every third clock, which is short enough to sweep every one of the 30 formats several times over. For each format it sends one frame from idle and then two more frames back to back. It scrambles the format and data inputs during every frame and predicts each line bit, including the parity bit, from arithmetic on the data. The reserved size and parity codes, a change of format between chained frames, and a reset in the middle of a frame are also covered.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int unsigned SFT_MAX_BITS = 9;
    localparam int unsigned SFT_MIN_BITS = 5;
    localparam int unsigned SFT_CNT_W    = $clog2(SFT_MAX_BITS + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } parity_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP1,
        PH_STOP2
    } phase_e;

    typedef struct packed {
        logic [SFT_CNT_W-1:0]    nbits;
        logic                    par_en;
        logic                    par_bit;
        logic                    two_stop;
        logic [SFT_MAX_BITS-1:0] data;
    } frame_t;

    // Size code to data-bit count; reserved codes select the widest size.
    function automatic logic [SFT_CNT_W-1:0] size_to_bits(input logic [2:0] code);
        logic [SFT_CNT_W-1:0] n;
        if (code > 3'd4) n = SFT_CNT_W'(SFT_MAX_BITS);
        else             n = SFT_CNT_W'(code) + SFT_CNT_W'(SFT_MIN_BITS);
        return n;
    endfunction

    // Parity over the low nbits of data; odd inverts the result.
    function automatic logic parity_of(input logic [SFT_MAX_BITS-1:0] data,
                                       input logic [SFT_CNT_W-1:0]    nbits,
                                       input logic                    odd);
        logic acc;
        acc = odd;
        for (int i = 0; i < SFT_MAX_BITS; i++) begin
            if (i < int'(nbits)) acc = acc ^ data[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/sft_fmt_capture.sv
module sft_fmt_capture
    import sft_pkg::*;
#(
    parameter int unsigned DATA_W = SFT_MAX_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [2:0]        cfg_size,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic [DATA_W-1:0] in_data,
    output frame_t            frm
);

    frame_t  nxt;
    parity_e pmode;

    always_comb begin
        pmode        = parity_e'(cfg_parity);
        nxt.nbits    = size_to_bits(cfg_size);
        nxt.par_en   = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
        nxt.two_stop = cfg_two_stop;
        nxt.data     = SFT_MAX_BITS'(in_data);
        nxt.par_bit  = parity_of(nxt.data, nxt.nbits, pmode == PAR_ODD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm <= '0;
        end else if (load) begin
            frm <= nxt;
        end
    end

endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
    import sft_pkg::*;
#(
    parameter int unsigned CNT_W = SFT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] nbits,
    input  logic             par_en,
    input  logic             two_stop,
    output phase_e           phase,
    output logic [CNT_W-1:0] bit_idx,
    output logic             last_stop
);

    phase_e           phase_n;
    logic [CNT_W-1:0] idx_n;

    assign last_stop = (phase == PH_STOP2) || ((phase == PH_STOP1) && !two_stop);

    always_comb begin
        phase_n = phase;
        idx_n   = bit_idx;
        if (load) begin
            phase_n = PH_START;
            idx_n   = '0;
        end else if (tick) begin
            unique case (phase)
                PH_IDLE:  phase_n = PH_IDLE;
                PH_START: begin
                    phase_n = PH_DATA;
                    idx_n   = '0;
                end
                PH_DATA: begin
                    if (bit_idx == nbits - CNT_W'(1)) begin
                        phase_n = par_en ? PH_PARITY : PH_STOP1;
                    end else begin
                        idx_n = bit_idx + CNT_W'(1);
                    end
                end
                PH_PARITY: phase_n = PH_STOP1;
                PH_STOP1:  phase_n = two_stop ? PH_STOP2 : PH_IDLE;
                PH_STOP2:  phase_n = PH_IDLE;
                default:   phase_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
        end else begin
            phase   <= phase_n;
            bit_idx <= idx_n;
        end
    end

endmodule

// File: rtl/sft_line_mux.sv
module sft_line_mux
    import sft_pkg::*;
#(
    parameter int unsigned DATA_W = SFT_MAX_BITS,
    parameter int unsigned CNT_W  = SFT_CNT_W
) (
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    output logic              line
);

    always_comb begin
        unique case (phase)
            PH_START:  line = 1'b0;
            PH_DATA:   line = data[bit_idx];
            PH_PARITY: line = par_bit;
            default:   line = 1'b1;
        endcase
    end

endmodule

// File: rtl/serframe_tx.sv
module serframe_tx
    import sft_pkg::*;
#(
    parameter int unsigned DATA_W = SFT_MAX_BITS,
    parameter int unsigned CNT_W  = SFT_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [2:0]        cfg_size,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tx_line
);

    frame_t           frm;
    phase_e           phase;
    logic [CNT_W-1:0] bit_idx;
    logic             last_stop;
    logic             load;

    assign in_ready = baud_tick && ((phase == PH_IDLE) || last_stop);
    assign load     = in_valid && in_ready;

    sft_fmt_capture #(.DATA_W(DATA_W)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .cfg_size     (cfg_size),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .in_data      (in_data),
        .frm          (frm)
    );

    sft_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .load      (load),
        .nbits     (frm.nbits),
        .par_en    (frm.par_en),
        .two_stop  (frm.two_stop),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .last_stop (last_stop)
    );

    sft_line_mux #(.DATA_W(SFT_MAX_BITS), .CNT_W(CNT_W)) u_mux (
        .phase   (phase),
        .bit_idx (bit_idx),
        .data    (frm.data),
        .par_bit (frm.par_bit),
        .line    (tx_line)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line
);

    // R1: accepted word produces a low start bit next cycle
    a_r1_start_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !tx_line);

    // R5: reset returns the line high
    a_r5_reset_line_high: assert property (@(posedge clk)
        rst |=> tx_line);

    // R6: ready only in a tick cycle
    a_r6_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> baud_tick);

    // R6: ready only while idle or in a stop bit, so the line is high
    a_r6_ready_line_high: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_line);

    // R9: the line moves only after a tick cycle
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(tx_line));

endmodule

bind serframe_tx sft_checker u_sft_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_line   (tx_line)
);

// File: tb/serframe_tx_test.sv
module serframe_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [2:0] cfg_size = 3'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic [8:0] in_data = 9'd0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       tx_line;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    serframe_tx uut (
        .clk          (clk),
        .rst          (rst),
        .baud_tick    (baud_tick),
        .cfg_size     (cfg_size),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .tx_line      (tx_line)
    );

    // baud tick on every third clock
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            baud_tick = (cnt == 2);
            cnt = (cnt + 1) % 3;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Send one frame; the bench ends at the final stop-bit tick cycle.
    task automatic tx_frame(input int code, input int par, input bit two,
                            input logic [8:0] d, input bit chained);
        logic e [16];
        string tag [16];
        int n, len, ones;
        n = (code > 4) ? 9 : code + 5;
        e[0] = 1'b0; tag[0] = "R1 start";
        ones = 0;
        for (int i = 0; i < n; i++) begin
            e[1 + i] = d[i];
            tag[1 + i] = "R2 data";
            ones += int'(d[i]);
        end
        len = 1 + n;
        if (par == 1 || par == 2) begin
            e[len] = (par == 1) ? logic'(ones % 2) : logic'((ones + 1) % 2);
            tag[len] = "R3 parity";
            len++;
        end
        e[len] = 1'b1; tag[len] = "R4 stop"; len++;
        if (two) begin
            e[len] = 1'b1; tag[len] = "R4 stop2"; len++;
        end

        cfg_size     = 3'(code);
        cfg_parity   = 2'(par);
        cfg_two_stop = two;
        in_data      = d;
        in_valid     = 1'b1;
        if (chained) check("R7 ready at last stop", int'(in_ready), 1);
        while (!in_ready) step();
        step();
        in_valid = 1'b0;
        // R8: disturb every format and data input during the frame
        cfg_size     = 3'(code + 2);
        cfg_parity   = 2'(par + 1);
        cfg_two_stop = ~two;
        in_data      = ~d;
        for (int k = 0; k < len; k++) begin
            while (!baud_tick) begin
                check({"R9 hold ", tag[k]}, int'(tx_line), int'(e[k]));
                check("R6 no ready off tick", int'(in_ready), 0);
                step();
            end
            check({tag[k], " R10 R8"}, int'(tx_line), int'(e[k]));
            check("R6 ready only at last stop", int'(in_ready), (k == len - 1) ? 1 : 0);
            if (k < len - 1) step();
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            check("R5 idle high", int'(tx_line), 1);
            check("R6 idle ready follows tick", int'(in_ready), int'(baud_tick));
        end
    endtask

    initial begin
        repeat (3) step();
        check("R5 line high in reset", int'(tx_line), 1);
        rst = 1'b0;
        idle_cycles(6);

        for (int code = 0; code < 5; code++) begin
            for (int par = 0; par < 3; par++) begin
                for (int two = 0; two < 2; two++) begin
                    logic [8:0] a, b, c;
                    a = 9'((code * 73 + par * 29 + two * 11) ^ 9'h0A5);
                    b = ~a;
                    c = (code + par + two) % 2 == 0 ? 9'h1FF : 9'h000;
                    idle_cycles(4);
                    tx_frame(code, par, bit'(two), a, 1'b0);
                    tx_frame(code, par, bit'(two), b, 1'b1);
                    tx_frame(code, par, bit'(two), c, 1'b1);
                end
            end
        end

        // R7: back to back with a change of format between frames
        idle_cycles(4);
        tx_frame(0, 2, 1'b1, 9'h013, 1'b0);
        tx_frame(4, 1, 1'b0, 9'h1C6, 1'b1);
        tx_frame(1, 0, 1'b0, 9'h02D, 1'b1);

        // R2 / R3: reserved size and parity codes
        idle_cycles(4);
        tx_frame(6, 3, 1'b0, 9'h15B, 1'b0);
        idle_cycles(4);
        tx_frame(7, 1, 1'b1, 9'h101, 1'b0);

        // R5: reset in the middle of a frame
        idle_cycles(4);
        cfg_size = 3'd3; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
        in_data = 9'h000; in_valid = 1'b1;
        while (!in_ready) step();
        step();
        in_valid = 1'b0;
        repeat (4) step();
        check("R5 line low mid frame", int'(tx_line), 0);
        rst = 1'b1;
        step();
        check("R5 reset mid frame high", int'(tx_line), 1);
        rst = 1'b0;
        idle_cycles(9);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule